// File: doc/BRIEF.md
# Microcode address generator

This block drives the microcode memory of a microcoded control unit. It keeps the 16-bit instruction word that is executing and a 3-bit step counter that advances once per cycle. From these two values, plus an exception request, it forms a 10-bit microcode address. There are three address shapes. Ordinary opcodes get eight consecutive slots each. R-type opcodes share a separate region, with thirty-two slots per opcode. A pending exception always runs from one fixed region.

While the active-low reset is held, the block stops decoding. It copies an external physical byte address straight onto the microcode address bus, and it raises one of eight RAM chip selects according to which 1 KB chunk that address lies in. An external loader uses this path to fill the microcode RAMs from serial storage before execution begins.

Top module: `ucode_addr_gen`

## Requirements
- R1: While `rst_n` is low, `uaddr` equals `phys_addr[9:0]`, combinationally.
- R2: While `rst_n` is low, `ram_sel` has exactly one bit set, at index `phys_addr[12:10]`.
- R3: While `rst_n` is high, `ram_sel` is all zero.
- R4: Reset clears `instr_q` and the step to 0, so `uaddr` is 0 right after release. After that the step increases by one on each clock edge and wraps from 7 to 0.
- R5: When `ir_load` is high at a clock edge, `instr_q` takes `instr_in` and the step returns to 0. When `ir_load` is low, `instr_in` is ignored.
- R6: The opcode is `instr_q[15:11]`. For an opcode below 24 with no exception active, `uaddr` = opcode*8 + step.
- R7: For an opcode of 24 or more with no exception active, `uaddr` = (32 + (opcode-24)*4)*8 + step, which is 256 + (opcode-24)*32 + step.
- R8: `exc_req` is registered. In every cycle that follows an edge where `exc_req` was high, `uaddr` = 0x300 + step. The edge at which `exc_req` is first seen high clears the step, so the exception sequence begins at 0x300.
- R9: An active exception overrides R-type decoding. With any opcode in `instr_q`, the address is exactly 0x300 + step, and no bits of the R-type address are merged in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; while low, selects microcode load mode |
| ir_load | input | 1 | Strobe that loads the instruction register |
| instr_in | input | 16 | Instruction word to load |
| exc_req | input | 1 | Exception request, level sensitive |
| phys_addr | input | 13 | Physical load address used during reset |
| instr_q | output | 16 | Instruction word currently held |
| uaddr | output | 10 | Microcode address |
| ram_sel | output | 8 | Active-high one-hot RAM chip selects, driven only in load mode |

## Verification
The clocked properties assume that `exc_req` and `ir_load` are stable around the rising edge. They also assume that no normal or R-type address can reach 0x300. Every computed form stays below 488, so the checker treats `uaddr[9:3] == 0x60` as proof that an exception is active. The load-mode checks assume that `phys_addr` changes only away from the rising edge. The stimulus changes every input on the falling edge. It sweeps all 8192 physical addresses under reset, then loads all 32 opcodes. Each opcode runs past a step wrap, then through an exception that lasts longer than eight cycles, and finally through an exception-time reload followed by its exit.

// File: rtl/ucode_addr_gen.sv
module ucode_addr_gen #(
  parameter int IW           = 16,
  parameter int OPW          = 5,
  parameter int STEP_W       = 3,
  parameter int UA_W         = 10,
  parameter int NSEL         = 8,
  parameter int RTYPE_FIRST  = 24,
  parameter int RTYPE_REGION = 256,
  parameter int RTYPE_SPAN   = 4,
  parameter int EXC_BASE     = 768,
  localparam int SEL_W       = $clog2(NSEL),
  localparam int PA_W        = UA_W + SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_load,
  input  logic [IW-1:0]   instr_in,
  input  logic            exc_req,
  input  logic [PA_W-1:0] phys_addr,
  output logic [IW-1:0]   instr_q,
  output logic [UA_W-1:0] uaddr,
  output logic [NSEL-1:0] ram_sel
);
  logic [STEP_W-1:0] step;
  logic              exc_act;
  logic [UA_W-1:0]   a_norm, a_rtyp, a_exc, a_run;

  wire [OPW-1:0] op        = instr_q[IW-1 -: OPW];
  wire           is_rtype  = op >= OPW'(RTYPE_FIRST);
  wire           exc_entry = exc_req & ~exc_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      step    <= '0;
      exc_act <= 1'b0;
    end else begin
      if (ir_load) instr_q <= instr_in;
      step    <= (ir_load || exc_entry) ? '0 : step + STEP_W'(1);
      exc_act <= exc_req;
    end
  end

  assign a_norm = (UA_W'(op) << STEP_W) + UA_W'(step);
  assign a_rtyp = UA_W'(RTYPE_REGION)
                + ((UA_W'(op - OPW'(RTYPE_FIRST)) * UA_W'(RTYPE_SPAN)) << STEP_W)
                + UA_W'(step);
  assign a_exc  = UA_W'(EXC_BASE) + UA_W'(step);
  assign a_run  = exc_act ? a_exc : (is_rtype ? a_rtyp : a_norm);

  assign uaddr   = rst_n ? a_run : phys_addr[UA_W-1:0];
  assign ram_sel = rst_n ? '0 : (NSEL'(1) << phys_addr[PA_W-1 -: SEL_W]);
endmodule

module ucode_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ir_load,
  input logic        exc_req,
  input logic [4:0]  op,
  input logic [12:0] phys_addr,
  input logic [9:0]  uaddr,
  input logic [7:0]  ram_sel
);
  wire in_exc = uaddr[9:3] == 7'h60;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_pass_r1: assert (uaddr == phys_addr[9:0]);
      p_onehot_r2: assert ($countones(ram_sel) == 1 && ram_sel[phys_addr[12:10]]);
    end
  end

  p_sel_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel == 8'h00);

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ir_load && !(exc_req && !in_exc)) |=> uaddr[2:0] == 3'($past(uaddr[2:0]) + 3'd1));

  p_load_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> uaddr[2:0] == 3'd0);

  p_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !ir_load && op < 5'd24) |=> uaddr[9:3] == {2'b00, $past(op)});

  p_rtype_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !ir_load && op >= 5'd24) |=> uaddr[9:3] == {2'b01, $past(op[2:0]), 2'b00});

  p_exc_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !in_exc) |=> uaddr == 10'h300);

  p_exc_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> uaddr[9:3] == 7'h60);
endmodule

bind ucode_addr_gen ucode_addr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .exc_req(exc_req),
  .op(instr_q[15:11]), .phys_addr(phys_addr), .uaddr(uaddr), .ram_sel(ram_sel)
);

// File: tb/tb_ucode_addr_gen.sv
`timescale 1ns/1ps
module tb_ucode_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_load = 1'b0;
  logic [15:0] instr_in = '0;
  logic        exc_req = 1'b0;
  logic [12:0] phys_addr = '0;
  logic [15:0] instr_q;
  logic [9:0]  uaddr;
  logic [7:0]  ram_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_ir;
  int          m_step;
  bit          m_exc;

  always #2 clk = ~clk;

  ucode_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .instr_in(instr_in),
    .exc_req(exc_req), .phys_addr(phys_addr), .instr_q(instr_q),
    .uaddr(uaddr), .ram_sel(ram_sel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input logic [15:0] ir, input int s, input bit e);
    int op;
    op = int'(ir[15:11]);
    if (e) return 768 + s;
    if (op >= 24) return (32 + (op - 24) * 4) * 8 + s;
    return op * 8 + s;
  endfunction

  task automatic tick(input bit ld, input logic [15:0] w, input bit ex, input string req);
    ir_load = ld; instr_in = w; exc_req = ex;
    @(posedge clk);
    if (ld) m_ir = w;
    m_step = (ld || (ex && !m_exc)) ? 0 : (m_step + 1) % 8;
    m_exc = ex;
    @(negedge clk);
    chk(req, int'(uaddr), exp_addr(m_ir, m_step, m_exc));
    chk("R5", int'(instr_q), int'(m_ir));
    chk("R3", int'(ram_sel), 0);
  endtask

  task automatic after_release();
    rst_n = 1'b1;
    m_ir = '0; m_step = 0; m_exc = 1'b0;
    #1;
    chk("R3", int'(ram_sel), 0);
    chk("R4", int'(uaddr), 0);
    chk("R4", int'(instr_q), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 8192; i++) begin
      phys_addr = 13'(i);
      @(posedge clk);
      @(negedge clk);
      chk("R1", int'(uaddr), i % 1024);
      chk("R2", int'(ram_sel), 1 << (i / 1024));
    end
    chk("R4", int'(instr_q), 0);
    after_release();
    for (int k = 0; k < 10; k++) tick(1'b0, 16'hffff, 1'b0, "R4");

    for (int op = 0; op < 32; op++) begin
      logic [15:0] w;
      string tag, etag;
      w    = {5'(op), 11'(op * 97 + 5)};
      tag  = (op >= 24) ? "R7" : "R6";
      etag = (op >= 24) ? "R9" : "R8";
      tick(1'b1, w, 1'b0, "R5");
      for (int k = 0; k < 9; k++) tick(1'b0, ~w, 1'b0, tag);
      for (int k = 0; k < 10; k++) tick(1'b0, 16'(k * 4111), 1'b1, etag);
      tick(1'b1, w ^ 16'h0155, 1'b1, "R5");
      for (int k = 0; k < 3; k++) tick(1'b0, ~w, 1'b0, tag);
    end

    rst_n = 1'b0;
    phys_addr = 13'h1abc;
    #1;
    chk("R1", int'(uaddr), 'h2bc);
    chk("R2", int'(ram_sel), 1 << 6);
    @(posedge clk);
    @(negedge clk);
    after_release();
    tick(1'b0, 16'h0, 1'b0, "R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule